// File: doc/BRIEF.md
# Variable-Length Serial Master Receiver

This block is a receive-only master for a three-wire clocked serial link. It drives a serial clock out and samples a serial data line in. There is no chip select and no transmit path. Software sets it up through a small write port: enable bits, bit order, a clock divider choice and a transfer length of 2 to 16 bits. It then fetches received words through a read strobe.

Reading the data register both returns the last received word and, when the block is idle and fully enabled, starts the next reception. The first transfer therefore begins with a dummy read. While the clock-enable bit stays set, each read of a finished word starts the next one, which gives continuous reception. Clearing that bit lets software collect the final word without starting another transfer. A `busy` output follows the transfer, and a one-cycle `irq` pulse marks its end.

The controller is a three-state machine. `ST_IDLE` holds the serial clock high. `ST_SCK_LO` drives the clock low for one system cycle, and the rising edge at its end captures a bit. `ST_SCK_HI` holds the clock high for the rest of the bit period. The transitions are:
- start: `ST_IDLE` to `ST_SCK_LO`.
- capture: `ST_SCK_LO` to `ST_SCK_HI`.
- finish: `ST_SCK_LO` to `ST_IDLE`, on the last bit.
- next bit: `ST_SCK_HI` to `ST_SCK_LO`, once the high time has run out.
- abort: any state to `ST_IDLE`, when power or receive enable is cleared.

Top module: `vsr_rx`

## Requirements
- R1: A strobe on `rd_en` starts a transfer only when all of these hold: the block is idle, and the power, receive-enable and clock-enable bits are all 1. `busy` then reads 1 from the next cycle on.
- R2: The 4-bit length code sets the number of bits per transfer. Code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 to 15 select that many bits.
- R3: `sck` is 1 whenever the block is idle. For each bit it is low for exactly one system cycle, and `sdi` is captured at the clock edge where `sck` rises. The bit period is 2 system cycles when the divider bit is 0 and 3 cycles when it is 1. The edge that completes the transfer comes (len-1)*period+1 cycles after the start edge.
- R4: The received word is right-aligned in the 16-bit data register, and the bits above the transfer length are 0. With the order bit at 0 (MSB first), the first received bit lands in bit len-1. With the order bit at 1 (LSB first), the first received bit lands in bit 0.
- R5: On completion, `irq` is 1 for exactly one cycle. In that same cycle `busy` has just fallen to 0 and `rd_data` shows the new word.
- R6: With the clock-enable bit at 0, a read returns the stored word on `rd_data` and does not start a transfer.
- R7: A read while `busy` is 1 returns the previous word and does not start or queue a transfer.
- R8: The data register changes only on the completion of a transfer.
- R9: Clearing the power or receive-enable bit ends any transfer within one cycle. `sck` returns high, no `irq` is raised, and the data register keeps its value.
- R10: The register map decodes `wr_addr` as follows, and all fields reset to 0, so the block starts disabled with `rd_data` = 0:
  - Address 0 holds power in bit 0, receive enable in bit 1, clock enable in bit 2 and bit order in bit 3.
  - Address 1 holds the divider select in bit 0.
  - Address 2 holds the length code in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 4 | Register write data |
| rd_en | input | 1 | Data register read strobe (may start a transfer) |
| rd_data | output | 16 | Last completed received word |
| sck | output | 1 | Serial clock out, idles high |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- The length code and the divider and order bits are not rewritten while `busy` is 1. Bit counting and word alignment read these fields live.
- `sdi` is stable from the falling `sck` edge to the next system clock edge.

The bench respects both assumptions. It writes configuration only between transfers, apart from the deliberate abort, which clears only the control bits. It drives each `sdi` bit from the falling edge of `sck`, one full system cycle before the capturing edge.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
    localparam int VSR_CODE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCK_LO = 2'd1,
        ST_SCK_HI = 2'd2
    } vsr_state_e;

    typedef struct packed {
        logic                  pwr;
        logic                  rxe;
        logic                  clk_en;
        logic                  lsb_first;
        logic                  div3;
        logic [VSR_CODE_W-1:0] len_code;
    } vsr_cfg_t;
endpackage

// File: rtl/vsr_regs.sv
module vsr_regs
    import vsr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [VSR_CODE_W-1:0] wr_data,
    output vsr_cfg_t              cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0: begin
                    cfg.pwr       <= wr_data[0];
                    cfg.rxe       <= wr_data[1];
                    cfg.clk_en    <= wr_data[2];
                    cfg.lsb_first <= wr_data[3];
                end
                2'd1:    cfg.div3     <= wr_data[0];
                2'd2:    cfg.len_code <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
    import vsr_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clk_en,
    input  logic             div3,
    input  logic [CNT_W-1:0] len,
    input  logic             rd_en,
    output logic             busy,
    output logic             sck,
    output logic             irq,
    output logic             start,
    output logic             capture,
    output logic             done
);
    vsr_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic             hi_cnt;
    logic             last_bit, hi_done;

    assign last_bit = (bit_cnt == len - CNT_W'(1));
    assign hi_done  = div3 ? hi_cnt : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (enable && clk_en && rd_en) state_d = ST_SCK_LO;
            ST_SCK_LO: state_d = last_bit ? ST_IDLE : ST_SCK_HI;
            ST_SCK_HI: if (hi_done) state_d = ST_SCK_LO;
            default:   state_d = ST_IDLE;
        endcase
        if (!enable) state_d = ST_IDLE;
    end

    always_comb begin
        sck     = (state_q != ST_SCK_LO);
        busy    = (state_q != ST_IDLE);
        start   = (state_q == ST_IDLE) && (state_d == ST_SCK_LO);
        capture = (state_q == ST_SCK_LO) && enable;
        done    = capture && last_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            hi_cnt  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= done;
            if (start)        bit_cnt <= '0;
            else if (capture) bit_cnt <= bit_cnt + CNT_W'(1);
            if (state_q != ST_SCK_HI) hi_cnt <= 1'b0;
            else                      hi_cnt <= ~hi_cnt;
        end
    end

    AST_START_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && rd_en && enable && clk_en) |=> busy); // R1
    AST_BITS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (bit_cnt < len)); // R2
    AST_SCK_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck); // R3
    AST_IRQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (!busy && $past(busy))); // R5
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R5
    AST_GATED_READ:    assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && !clk_en) |=> !busy); // R6
    AST_ABORT_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !enable |=> (!busy && !irq)); // R9
endmodule

// File: rtl/vsr_shifter.sv
module vsr_shifter #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              done,
    input  logic              sdi,
    input  logic              lsb_first,
    input  logic [CNT_W-1:0]  len,
    output logic [DATA_W-1:0] data_q
);
    logic [DATA_W-1:0] sr_q, sr_d, word;

    always_comb begin
        if (lsb_first) begin
            sr_d = {sdi, sr_q[DATA_W-1:1]};
            word = sr_d >> (CNT_W'(DATA_W) - len);
        end else begin
            sr_d = {sr_q[DATA_W-2:0], sdi};
            word = sr_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            data_q <= '0;
        end else begin
            if (clear)        sr_q <= '0;
            else if (capture) sr_q <= sr_d;
            if (done)         data_q <= word;
        end
    end

    AST_DATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(data_q) |-> $past(done)); // R8
    AST_CLEAR_NOT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) !(clear && capture)); // R1
endmodule

// File: rtl/vsr_rx.sv
module vsr_rx
    import vsr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DEFAULT_LEN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [VSR_CODE_W-1:0] wr_data,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  sck,
    input  logic                  sdi,
    output logic                  busy,
    output logic                  irq
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    vsr_cfg_t         cfg;
    logic [CNT_W-1:0] len;
    logic             start, capture, done;

    always_comb begin
        if (cfg.len_code == '0)                   len = CNT_W'(DEFAULT_LEN);
        else if (cfg.len_code == VSR_CODE_W'(1))  len = CNT_W'(DATA_W);
        else                                      len = CNT_W'(cfg.len_code);
    end

    vsr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg)
    );

    vsr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(cfg.pwr && cfg.rxe),
        .clk_en(cfg.clk_en), .div3(cfg.div3), .len(len), .rd_en(rd_en),
        .busy(busy), .sck(sck), .irq(irq), .start(start),
        .capture(capture), .done(done)
    );

    vsr_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(start), .capture(capture),
        .done(done), .sdi(sdi), .lsb_first(cfg.lsb_first), .len(len),
        .data_q(rd_data)
    );

    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && rd_en && !done) |=> busy); // R7
endmodule

// File: tb/vsr_rx_bench.sv
`timescale 1ns/1ps
module vsr_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        sck, sdi = 1'b0, busy, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [15:0] tx_cur = '0;
    int bit_idx = 0;

    always #2.5 clk = ~clk;

    vsr_rx u_vsr_rx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .sck(sck),
        .sdi(sdi), .busy(busy), .irq(irq)
    );

    always @(negedge sck) begin
        if (bit_idx < 16) sdi = tx_cur[bit_idx];
        bit_idx = bit_idx + 1;
    end

    // fields: [21] div3, [20] lsb first, [19:16] length code, [15:0] bits in send order from bit 0
    localparam logic [21:0] VEC [0:6] = '{
        {1'b0, 1'b0, 4'd0,  16'h00B4},
        {1'b1, 1'b0, 4'd0,  16'h005A},
        {1'b0, 1'b1, 4'd0,  16'h00C3},
        {1'b0, 1'b0, 4'd1,  16'h9E37},
        {1'b1, 1'b1, 4'd2,  16'h0001},
        {1'b0, 1'b1, 4'd15, 16'h2F1D},
        {1'b1, 1'b0, 4'd5,  16'h0013}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [3:0] code);
        if (code == 4'd0) return 8;
        if (code == 4'd1) return 16;
        return int'(code);
    endfunction

    function automatic logic [15:0] exp_word(input logic lsb, input int len, input logic [15:0] tx);
        logic [15:0] w = '0;
        for (int i = 0; i < len; i++) begin
            if (lsb) w[i] = tx[i];
            else     w[len-1-i] = tx[i];
        end
        return w;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 1;
        while (!irq && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        if (!finished) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v, w_a, w_b, prev;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sck == 1'b1 && busy == 1'b0 && irq == 1'b0, "R10 reset outputs", {sck, busy, irq}, 3'b100);
        check(rd_data == 16'h0, "R10 reset data", rd_data, 0);
        rd(v);
        check(busy == 1'b0, "R10 disabled at reset", busy, 0);

        for (int k = 0; k < 7; k++) begin
            logic div3, lsb;
            logic [3:0] code;
            logic [15:0] tx;
            int len;
            {div3, lsb, code, tx} = VEC[k];
            len = len_of(code);
            wr(2'd1, {3'b0, div3});
            wr(2'd2, code);
            wr(2'd0, {lsb, 3'b111});
            tx_cur = tx; bit_idx = 0;
            rd(v);
            wait_irq(n);
            check(n == (len - 1) * (div3 ? 3 : 2) + 2, "R3 transfer cycles", n, (len - 1) * (div3 ? 3 : 2) + 2);
            check(busy == 1'b0, "R5 busy low with irq", busy, 0);
            check(rd_data == exp_word(lsb, len, tx), "R2 R4 received word", rd_data, exp_word(lsb, len, tx));
            @(negedge clk);
            check(irq == 1'b0 && busy == 1'b0, "R5 single pulse", {irq, busy}, 0);
        end

        // R6: clock enable off, read only returns data
        prev = rd_data;
        wr(2'd0, 4'b0011);
        rd(v);
        check(v == prev, "R6 read data", v, prev);
        check(busy == 1'b0, "R6 no start", busy, 0);
        repeat (3) @(negedge clk);
        check(rd_data == prev, "R8 data held", rd_data, prev);

        // R7: read while busy
        wr(2'd1, 4'd0); wr(2'd2, 4'd0); wr(2'd0, 4'b0111);
        tx_cur = 16'h0069; bit_idx = 0;
        rd(v);
        repeat (3) @(negedge clk);
        rd(v);
        check(v == prev, "R7 busy read returns old word", v, prev);
        check(busy == 1'b1, "R7 still busy", busy, 1);
        wait_irq(n);
        w_a = exp_word(1'b0, 8, 16'h0069);
        check(rd_data == w_a, "R7 word after busy read", rd_data, w_a);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R7 no queued start", busy, 0);

        // R1: continuous reception
        tx_cur = 16'h00F0; bit_idx = 0;
        rd(v);
        check(v == w_a, "R1 continuous read data", v, w_a);
        check(busy == 1'b1, "R1 continuous restart", busy, 1);
        wait_irq(n);
        w_b = exp_word(1'b0, 8, 16'h00F0);
        check(rd_data == w_b, "R1 continuous second word", rd_data, w_b);

        // R9: abort by clearing power
        tx_cur = 16'h00FF; bit_idx = 0;
        rd(v);
        repeat (4) @(negedge clk);
        wr(2'd0, 4'b0110);
        @(negedge clk);
        check(busy == 1'b0 && sck == 1'b1, "R9 abort idle", {busy, sck}, 2'b01);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq) n++;
        end
        check(n == 0, "R9 no irq after abort", n, 0);
        check(rd_data == w_b, "R9 data kept", rd_data, w_b);

        // R9/R1: receive enable off blocks start
        wr(2'd0, 4'b0101);
        rd(v);
        check(busy == 1'b0, "R9 rxe off no start", busy, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule